// File: doc/BRIEF.md
# Lane Swizzle Permutation Unit

The unit moves 32-bit values between the 32 lanes of a vector register in one registered step. A three-bit mode code chooses one of five lane-mapping rules: quad permute, bitmask permute, group broadcast, neighbour-group swap or group reverse. A small set of control fields supplies the parameters for the chosen rule. For every output lane, the mapping gives the source lane it reads from.

A per-lane execute mask gates the result. An inactive destination lane receives zero. A value read from an inactive source lane is also zero. Some control combinations are illegal: a group size outside the legal set for the mode, or an undefined mode code. For these, the unit raises an error flag and returns the input vector unchanged.

A request is presented with `in_valid`. The permuted vector, the error flag and `out_valid` appear on the following clock edge. The output data holds its value between requests.

Top module: `lane_swizzle`

## Requirements
- R1: Under synchronous active-high reset, `out_valid`, `out_err` and every bit of `out_data` are zero on the next edge.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. When `in_valid` is low, `out_data` and `out_err` keep their values.
- R3: Mode 0 (quad permute): output lane i reads lane `(i & ~3) | q`. Here q is `quad_sel[2m+1:2m]` and m = i mod 4.
- R4: Mode 1 (bitmask permute): for each source-id bit b, `bm_ops[2b+1:2b]` selects the rule. Code 0 forces the bit to 0, 1 forces it to 1, 2 keeps it and 3 inverts it.
- R5: Mode 2 (broadcast): with group size S in {2,4,8,16,32}, lane i reads lane `(i & ~(S-1)) | (bc_lane & (S-1))`. Index bits at or above S are ignored.
- R6: Mode 3 (swap): with S in {1,2,4,8,16}, lane i reads lane `i ^ S`.
- R7: Mode 4 (reverse): with S in {2,4,8,16,32}, lane i reads lane `i ^ (S-1)`.
- R8: An output lane is zero when its own `exec_mask` bit is 0, or when the `exec_mask` bit of its source lane is 0.
- R9: With all control inputs at zero, every lane reads lane 0 of its own quad.
- R10: A group size outside the legal set of modes 2, 3 or 4, or a mode code of 5 to 7, sets `out_err`. In that case `out_data` equals `in_data` exactly, with no masking. Legal requests clear `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Mapping rule code (0..4 defined) |
| quad_sel | input | 8 | Four 2-bit quad selectors |
| bm_ops | input | 10 | Five 2-bit per-bit rules for bitmask mode |
| grp_size | input | 6 | Group size for broadcast, swap and reverse |
| bc_lane | input | 5 | Broadcast lane index |
| exec_mask | input | 32 | Per-lane active bits |
| in_data | input | 32*DW | Lane values, lane i at bits [i*DW +: DW] |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Illegal control seen on this result |
| out_data | output | 32*DW | Permuted lane values |

## Verification
The assertions assume that the control fields and data are steady around the sampling edge, and that reset lasts at least one edge before checking starts. The bench drives every input on the falling edge, so each request is settled well before the rising edge that captures it. The stimulus covers every legal group size per mode and broadcast indices larger than the group. It also covers non-power-of-two, zero and out-of-range sizes, undefined mode codes and sparse execute masks. Idle gaps sit between bursts so that data holding is observed.

// File: rtl/swz_pkg.sv
package swz_pkg;
    localparam int LANES = 32;
    localparam int LIDW  = $clog2(LANES);
    localparam int QSELW = 8;

    typedef enum logic [2:0] {
        SWZ_QUAD    = 3'd0,
        SWZ_BITMASK = 3'd1,
        SWZ_BCAST   = 3'd2,
        SWZ_SWAP    = 3'd3,
        SWZ_REV     = 3'd4
    } swz_mode_e;

    typedef enum logic [1:0] {
        BIT_ZERO = 2'd0,
        BIT_ONE  = 2'd1,
        BIT_KEEP = 2'd2,
        BIT_FLIP = 2'd3
    } bit_op_e;

    typedef struct packed {
        swz_mode_e             mode;
        logic [QSELW-1:0]      quad_sel;
        logic [2*LIDW-1:0]     bm_ops;
        logic [LIDW:0]         grp_size;
        logic [LIDW-1:0]       bc_lane;
    } swz_ctrl_t;

    function automatic logic is_pow2(input logic [LIDW:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/swz_index_gen.sv
module swz_index_gen
    import swz_pkg::*;
(
    input  swz_ctrl_t               ctrl,
    output logic [LANES*LIDW-1:0]   src_idx,
    output logic                    bad
);
    logic [LIDW:0]   size_m1;
    logic [LIDW-1:0] grp_mask;
    logic            size_p2;

    assign size_m1  = ctrl.grp_size - 1'b1;
    assign grp_mask = size_m1[LIDW-1:0];
    assign size_p2  = is_pow2(ctrl.grp_size);

    always_comb begin
        case (ctrl.mode)
            SWZ_QUAD, SWZ_BITMASK: bad = 1'b0;
            SWZ_BCAST, SWZ_REV:    bad = !(size_p2 && ctrl.grp_size >= 2 &&
                                           ctrl.grp_size <= (LIDW+1)'(LANES));
            SWZ_SWAP:              bad = !(size_p2 && ctrl.grp_size <= (LIDW+1)'(LANES/2));
            default:               bad = 1'b1;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LIDW-1:0] ID = LIDW'(i);
        logic [LIDW-1:0] bm_src;

        for (genvar b = 0; b < LIDW; b++) begin : g_bit
            always_comb begin
                case (bit_op_e'(ctrl.bm_ops[2*b +: 2]))
                    BIT_ZERO: bm_src[b] = 1'b0;
                    BIT_ONE:  bm_src[b] = 1'b1;
                    BIT_KEEP: bm_src[b] = ID[b];
                    default:  bm_src[b] = ~ID[b];
                endcase
            end
        end

        always_comb begin
            case (ctrl.mode)
                SWZ_QUAD:    src_idx[i*LIDW +: LIDW] =
                                 {ID[LIDW-1:2], ctrl.quad_sel[2*(i%4) +: 2]};
                SWZ_BITMASK: src_idx[i*LIDW +: LIDW] = bm_src;
                SWZ_BCAST:   src_idx[i*LIDW +: LIDW] =
                                 (ID & ~grp_mask) | (ctrl.bc_lane & grp_mask);
                SWZ_SWAP:    src_idx[i*LIDW +: LIDW] = ID ^ ctrl.grp_size[LIDW-1:0];
                SWZ_REV:     src_idx[i*LIDW +: LIDW] = ID ^ grp_mask;
                default:     src_idx[i*LIDW +: LIDW] = ID;
            endcase
        end
    end
endmodule

// File: rtl/swz_xbar.sv
module swz_xbar
    import swz_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [LANES*DW-1:0]   data_in,
    input  logic [LANES-1:0]      exec_mask,
    input  logic [LANES*LIDW-1:0] src_idx,
    output logic [LANES*DW-1:0]   data_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_out
        logic [LIDW-1:0] src;
        assign src = src_idx[k*LIDW +: LIDW];
        always_comb begin
            if (exec_mask[k] && exec_mask[src])
                data_out[k*DW +: DW] = data_in[src*DW +: DW];
            else
                data_out[k*DW +: DW] = '0;
        end
    end
endmodule

// File: rtl/lane_swizzle.sv
module lane_swizzle
    import swz_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2:0]            mode,
    input  logic [QSELW-1:0]      quad_sel,
    input  logic [2*LIDW-1:0]     bm_ops,
    input  logic [LIDW:0]         grp_size,
    input  logic [LIDW-1:0]       bc_lane,
    input  logic [LANES-1:0]      exec_mask,
    input  logic [LANES*DW-1:0]   in_data,
    output logic                  out_valid,
    output logic                  out_err,
    output logic [LANES*DW-1:0]   out_data
);
    swz_ctrl_t             ctrl;
    logic [LANES*LIDW-1:0] src_idx;
    logic                  bad;
    logic [LANES*DW-1:0]   permuted;

    assign ctrl = '{mode: swz_mode_e'(mode), quad_sel: quad_sel, bm_ops: bm_ops,
                    grp_size: grp_size, bc_lane: bc_lane};

    swz_index_gen u_idx (
        .ctrl    (ctrl),
        .src_idx (src_idx),
        .bad     (bad)
    );

    swz_xbar #(.DW(DW)) u_xbar (
        .data_in   (in_data),
        .exec_mask (exec_mask),
        .src_idx   (src_idx),
        .data_out  (permuted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err  <= bad;
                out_data <= bad ? in_data : permuted;
            end
        end
    end

    // R2: valid follows the request by one edge
    p_valid_next_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R10: illegal controls pass the input straight through
    p_err_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bad) |=> (out_err && out_data == $past(in_data)));

    // R3, R4: the quad and bitmask rules never report an error
    p_noerr_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode == 3'd0 || mode == 3'd1)) |=> !out_err);

    // R8: an inactive destination lane always reads zero
    for (genvar k = 0; k < LANES; k++) begin : g_chk
        p_inactive_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !bad && !exec_mask[k]) |=> out_data[k*DW +: DW] == '0);
    end
endmodule

// File: tb/tb_lane_swizzle.sv
`timescale 1ns/1ps
module tb_lane_swizzle;
    localparam int NL = 32;
    localparam int W  = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [2:0]      mode;
    logic [7:0]      quad_sel;
    logic [9:0]      bm_ops;
    logic [5:0]      grp_size;
    logic [4:0]      bc_lane;
    logic [NL-1:0]   exec_mask;
    logic [NL*W-1:0] in_data;
    logic            out_valid;
    logic            out_err;
    logic [NL*W-1:0] out_data;

    lane_swizzle #(.DW(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .quad_sel(quad_sel), .bm_ops(bm_ops), .grp_size(grp_size),
        .bc_lane(bc_lane), .exec_mask(exec_mask), .in_data(in_data),
        .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic            m_valid, m_err;
    logic [NL*W-1:0] m_data;
    string           tag;

    function automatic bit size_ok(int md, int sz);
        case (md)
            0, 1:    return 1;
            2, 4:    return sz == 2 || sz == 4 || sz == 8 || sz == 16 || sz == 32;
            3:       return sz == 1 || sz == 2 || sz == 4 || sz == 8 || sz == 16;
            default: return 0;
        endcase
    endfunction

    function automatic int src_of(int i);
        int s;
        case (int'(mode))
            0: s = (i / 4) * 4 + int'((quad_sel >> (2 * (i % 4))) & 8'h3);
            1: begin
                s = 0;
                for (int b = 0; b < 5; b++) begin
                    int op  = int'((bm_ops >> (2 * b)) & 10'h3);
                    int bit_v = (i >> b) & 1;
                    int r = (op == 0) ? 0 : (op == 1) ? 1 : (op == 2) ? bit_v : 1 - bit_v;
                    s = s + (r << b);
                end
            end
            2: s = (i - (i % int'(grp_size))) + (int'(bc_lane) % int'(grp_size));
            3: s = i ^ int'(grp_size);
            default: s = (i - (i % int'(grp_size))) + (int'(grp_size) - 1 - (i % int'(grp_size)));
        endcase
        return s;
    endfunction

    task automatic model_step();
        if (rst) begin
            m_valid = 0; m_err = 0; m_data = '0;
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                m_err = !size_ok(int'(mode), int'(grp_size));
                if (m_err) m_data = in_data;
                else
                    for (int i = 0; i < NL; i++) begin
                        int s = src_of(i);
                        m_data[i*W +: W] = (exec_mask[i] && exec_mask[s]) ? in_data[s*W +: W] : '0;
                    end
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== m_valid || out_err !== m_err || out_data !== m_data) begin
            errors++;
            $display("FAIL %s: valid=%0b/%0b err=%0b/%0b (actual/expected)",
                     tag, out_valid, m_valid, out_err, m_err);
            for (int i = 0; i < NL; i++)
                if (out_data[i*W +: W] !== m_data[i*W +: W]) begin
                    $display("FAIL %s: lane %0d actual %h expected %h",
                             tag, i, out_data[i*W +: W], m_data[i*W +: W]);
                    break;
                end
        end
    endtask

    task automatic randomize_data();
        for (int i = 0; i < NL; i++) in_data[i*W +: W] = $urandom();
    endtask

    task automatic step(input string t, input bit v, input int md, input int qs,
                        input int bo, input int sz, input int bl);
        tag = t; in_valid = v; mode = 3'(md); quad_sel = 8'(qs); bm_ops = 10'(bo);
        grp_size = 6'(sz); bc_lane = 5'(bl);
        randomize_data();
        @(negedge clk);
        model_step();
        compare();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; mode = 0; quad_sel = 0; bm_ops = 0; grp_size = 0;
        bc_lane = 0; exec_mask = '1; in_data = '0;
        m_valid = 0; m_err = 0; m_data = '0;
        @(negedge clk);
        // R1: reset state, even with a request presented
        step("R1", 1, 0, 8'h1B, 0, 0, 0);
        step("R1", 0, 0, 0, 0, 0, 0);
        rst = 0;
        // R9: all-zero controls
        step("R9", 1, 0, 0, 0, 0, 0);
        // R3: quad permute patterns
        step("R3", 1, 0, 8'hE4, 0, 0, 0);
        step("R3", 1, 0, 8'h1B, 0, 0, 0);
        for (int n = 0; n < 6; n++) step("R3", 1, 0, int'($urandom() & 8'hFF), 0, 0, 0);
        // R2: idle gap holds data, then back-to-back requests
        step("R2", 0, 0, 0, 0, 0, 0);
        step("R2", 0, 3, 0, 0, 7, 0);
        step("R2", 1, 4, 0, 0, 32, 0);
        step("R2", 0, 0, 0, 0, 0, 0);
        // R4: bitmask permute rules
        step("R4", 1, 1, 0, 10'h2AA, 0, 0);
        step("R4", 1, 1, 0, 10'h3FF, 0, 0);
        step("R4", 1, 1, 0, 10'h155, 0, 0);
        step("R4", 1, 1, 0, 10'h000, 0, 0);
        for (int n = 0; n < 8; n++) step("R4", 1, 1, 0, int'($urandom() & 10'h3FF), 0, 0);
        // R5: broadcast, including indices beyond the group
        for (int sh = 1; sh <= 5; sh++)
            for (int bl = 0; bl < 32; bl += 5) step("R5", 1, 2, 0, 0, 1 << sh, bl);
        // R6: swap sizes
        for (int sh = 0; sh <= 4; sh++) step("R6", 1, 3, 0, 0, 1 << sh, 0);
        // R7: reverse sizes
        for (int sh = 1; sh <= 5; sh++) step("R7", 1, 4, 0, 0, 1 << sh, 0);
        // R8: sparse execute masks across every mode
        for (int n = 0; n < 40; n++) begin
            int md = n % 5;
            int sz = (md == 3) ? (1 << (n % 5)) : (2 << (n % 5));
            exec_mask = $urandom();
            step("R8", 1, md, int'($urandom() & 8'hFF), int'($urandom() & 10'h3FF),
                 sz, int'($urandom() & 5'h1F));
        end
        exec_mask = 32'h0000_0000;
        step("R8", 1, 2, 0, 0, 4, 1);
        // R10: illegal sizes and undefined mode codes, with masking off
        exec_mask = 32'h0F0F_00FF;
        step("R10", 1, 3, 0, 0, 3, 0);
        step("R10", 1, 3, 0, 0, 0, 0);
        step("R10", 1, 3, 0, 0, 32, 0);
        step("R10", 1, 4, 0, 0, 1, 0);
        step("R10", 1, 4, 0, 0, 6, 0);
        step("R10", 1, 2, 0, 0, 5, 3);
        step("R10", 1, 2, 0, 0, 0, 0);
        step("R10", 1, 5, 0, 0, 4, 0);
        step("R10", 1, 7, 0, 0, 4, 0);
        step("R10", 0, 0, 0, 0, 0, 0);
        step("R10", 1, 3, 0, 0, 8, 0);
        // R1: reset again from a busy state
        rst = 1;
        step("R1", 1, 0, 0, 0, 0, 0);
        rst = 0;
        step("R2", 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule